// File: doc/BRIEF.md
# Boot Failover Watchdog

This block watches a system boot from a primary serial boot flash. It counts whole seconds from a one-pulse-per-second tick and compares the count against a timeout that software programs. If the timeout is reached before software reports that the boot has finished, the block sets a sticky failure flag and pulses a fixed-length system reset. From then on it steers flash accesses to the backup image.

There are two ways to reach the backup image, and a configuration bit picks one. The first drives a second chip-select line to reach a separate device. The second forces the top address bit so the upper half of a larger single device is used (for example the second 4 Mbit half of an 8 Mbit part). The failure flag, and with it the steering, survives the reset the block generates itself. Writing 1 to the status bit releases it. The serial shifting itself belongs to another block.

Top module: `boot_failover_wdt`

## Requirements
- R1: After the synchronous reset `rst`, `sys_rst_o`, `fail_o`, `cs_sel_o` and `addr_msb_o` are 0, the timeout register is 0 and the seconds count is 0.
- R2: With `en` high, a nonzero timeout T and boot-done clear, `fail_o` rises on the clock edge that samples the tick bringing the count, started from zero, to T. The same edge fires if the count would reach or pass T, so a timeout lowered below the current count fires on the next tick.
- R3: A timeout drives `sys_rst_o` high for exactly 16 consecutive cycles, starting in the cycle after the edge that set `fail_o`.
- R4: A timeout value of 0 disables the watchdog: no number of ticks sets `fail_o`.
- R5: While `en` is low the seconds count is held at zero, so ticks seen before `en` dropped do not count toward the timeout.
- R6: Writing 1 to bit 1 of the control register (address 1) stops the count and prevents a timeout. Writing 0 to that bit resumes counting from the held value.
- R7: Bit 0 of the control register picks the backup method. With 0, a failure drives `cs_sel_o`=1 and `addr_msb_o`=0. With 1, it drives `addr_msb_o`=1 and `cs_sel_o`=0. Without a failure both are 0.
- R8: `fail_o` is sticky. Writing 1 to bit 0 of the status register (address 2) clears it. Writing 0 there has no effect. The timeout register is at address 0.
- R9: While `fail_o` or `sys_rst_o` is high the seconds count is held at zero, so no second reset is generated. After a clear, counting restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Watchdog enable |
| sec_tick | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 timeout, 1 control, 2 status |
| wr_data | input | 8 | Register write data |
| sys_rst_o | output | 1 | System reset pulse on timeout |
| fail_o | output | 1 | Sticky primary-boot failure flag |
| cs_sel_o | output | 1 | Chip-select steering: 1 selects the backup device |
| addr_msb_o | output | 1 | Address MSB steering: 1 selects the upper half |

## Verification
The assertions check four things on every cycle. The reset pulse must last exactly 16 cycles and start together with the failure flag. The flag must hold until a write of 1 clears it. The count must stay at zero while a failure is pending. No timeout may come from a zero timeout or while boot-done is set. The bench's scenarios are needed for the rest: the exact tick on which a timeout fires, resumption after boot-done is released, loss of progress when enable drops, and the choice between the two steering methods. Those depend on sequences of writes and ticks.

// File: rtl/boot_wdt_pkg.sv
package boot_wdt_pkg;

    localparam int unsigned REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_TIMEOUT = 2'd0,
        REG_CTRL    = 2'd1,
        REG_STATUS  = 2'd2
    } reg_addr_e;

    typedef struct packed {
        logic upper_half;
        logic boot_done;
    } ctrl_t;

    typedef struct packed {
        logic backup_cs;
        logic backup_msb;
    } steer_t;

    function automatic steer_t steer_of(input logic failed, input ctrl_t c);
        steer_t s;
        s.backup_cs  = failed & ~c.upper_half;
        s.backup_msb = failed &  c.upper_half;
        return s;
    endfunction

endpackage

// File: rtl/wdt_cfg_regs.sv
module wdt_cfg_regs
    import boot_wdt_pkg::*;
#(
    parameter int unsigned TMO_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [TMO_W-1:0]      wr_data,
    input  logic                  expire,
    output logic [TMO_W-1:0]      tmo_q,
    output ctrl_t                 ctrl_q,
    output logic                  fail_q
);

    logic clr_req;
    assign clr_req = wr_en && (reg_addr_e'(wr_addr) == REG_STATUS) && wr_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            tmo_q  <= '0;
            ctrl_q <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                REG_TIMEOUT: tmo_q <= wr_data;
                REG_CTRL: begin
                    ctrl_q.upper_half <= wr_data[0];
                    ctrl_q.boot_done  <= wr_data[1];
                end
                default: ;
            endcase
        end
    end

    // A timeout in the same cycle as a clear wins.
    always_ff @(posedge clk) begin
        if (rst)          fail_q <= 1'b0;
        else if (expire)  fail_q <= 1'b1;
        else if (clr_req) fail_q <= 1'b0;
    end

endmodule

// File: rtl/wdt_sec_counter.sv
module wdt_sec_counter #(
    parameter int unsigned TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             sec_tick,
    input  logic             hold,
    input  logic             blocked,
    input  logic [TMO_W-1:0] tmo,
    output logic [TMO_W-1:0] cnt_q,
    output logic             expire
);

    localparam int unsigned CW = TMO_W + 1;

    logic          zero_cnt;
    logic [CW-1:0] next_cnt;

    assign zero_cnt = !en || (tmo == '0) || blocked;
    assign next_cnt = {1'b0, cnt_q} + CW'(1);
    assign expire   = !zero_cnt && !hold && sec_tick && (next_cnt >= {1'b0, tmo});

    always_ff @(posedge clk) begin
        if (rst || zero_cnt)        cnt_q <= '0;
        else if (sec_tick && !hold) cnt_q <= expire ? '0 : next_cnt[TMO_W-1:0];
    end

endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
    parameter int unsigned RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic active
);

    localparam int unsigned PW = $clog2(RST_CYCLES + 1);

    logic [PW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)                 left_q <= '0;
        else if (fire)           left_q <= PW'(RST_CYCLES);
        else if (left_q != '0)   left_q <= left_q - PW'(1);
    end

    assign active = (left_q != '0);

endmodule

// File: rtl/boot_failover_wdt.sv
module boot_failover_wdt
    import boot_wdt_pkg::*;
#(
    parameter int unsigned TMO_W      = 8,
    parameter int unsigned RST_CYCLES = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic                  sec_tick,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [TMO_W-1:0]      wr_data,
    output logic                  sys_rst_o,
    output logic                  fail_o,
    output logic                  cs_sel_o,
    output logic                  addr_msb_o
);

    logic [TMO_W-1:0] tmo_q;
    logic [TMO_W-1:0] sec_cnt;
    ctrl_t            ctrl_q;
    logic             done_q;
    logic             fail_q;
    logic             expire;
    logic             pulse_on;
    steer_t           steer;

    wdt_cfg_regs #(.TMO_W(TMO_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .expire  (expire),
        .tmo_q   (tmo_q),
        .ctrl_q  (ctrl_q),
        .fail_q  (fail_q)
    );

    assign done_q = ctrl_q.boot_done;

    wdt_sec_counter #(.TMO_W(TMO_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .sec_tick (sec_tick),
        .hold     (done_q),
        .blocked  (fail_q || pulse_on),
        .tmo      (tmo_q),
        .cnt_q    (sec_cnt),
        .expire   (expire)
    );

    wdt_rst_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .fire   (expire),
        .active (pulse_on)
    );

    assign steer      = steer_of(fail_q, ctrl_q);
    assign sys_rst_o  = pulse_on;
    assign fail_o     = fail_q;
    assign cs_sel_o   = steer.backup_cs;
    assign addr_msb_o = steer.backup_msb;

endmodule

// File: rtl/boot_failover_wdt_chk.sv
module boot_failover_wdt_chk #(
    parameter int unsigned TMO_W      = 8,
    parameter int unsigned RST_CYCLES = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             sys_rst_o,
    input logic             fail_o,
    input logic             cs_sel_o,
    input logic             addr_msb_o,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [TMO_W-1:0] wr_data,
    input logic [TMO_W-1:0] tmo_q,
    input logic             done_q,
    input logic [TMO_W-1:0] sec_cnt
);

    localparam int unsigned LW = $clog2(RST_CYCLES + 2);

    logic [LW-1:0] hi_len;

    always_ff @(posedge clk) begin
        if (rst)            hi_len <= '0;
        else if (sys_rst_o) hi_len <= hi_len + LW'(1);
        else                hi_len <= '0;
    end

    // R3
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_rst_o) |-> (hi_len == LW'(RST_CYCLES)));

    // R3
    pulse_bound_chk: assert property (@(posedge clk) disable iff (rst)
        sys_rst_o |-> (hi_len < LW'(RST_CYCLES)));

    // R2
    pulse_with_fail_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_o) |-> $rose(fail_o));

    // R7
    steer_match_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cs_sel_o, addr_msb_o}) && ((cs_sel_o || addr_msb_o) == fail_o));

    // R8
    sticky_fail_chk: assert property (@(posedge clk) disable iff (rst)
        (fail_o && !(wr_en && wr_addr == 2'd2 && wr_data[0])) |=> fail_o);

    // R9
    cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (fail_o || sys_rst_o) |-> (sec_cnt == '0));

    // R4
    zero_tmo_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fail_o) |-> ($past(tmo_q) != '0));

    // R6
    done_block_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fail_o) |-> !$past(done_q));

endmodule

bind boot_failover_wdt boot_failover_wdt_chk #(.TMO_W(TMO_W), .RST_CYCLES(RST_CYCLES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sys_rst_o  (sys_rst_o),
    .fail_o     (fail_o),
    .cs_sel_o   (cs_sel_o),
    .addr_msb_o (addr_msb_o),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .tmo_q      (tmo_q),
    .done_q     (done_q),
    .sec_cnt    (sec_cnt)
);

// File: tb/tb_boot_failover_wdt.sv
`timescale 1ns/1ps
module tb_boot_failover_wdt;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       sec_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       sys_rst_o, fail_o, cs_sel_o, addr_msb_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    boot_failover_wdt dut (
        .clk(clk), .rst(rst), .en(en), .sec_tick(sec_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sys_rst_o(sys_rst_o), .fail_o(fail_o),
        .cs_sel_o(cs_sel_o), .addr_msb_o(addr_msb_o)
    );

    // Behavioural reference model
    int m_cnt = 0, m_left = 0, m_tmo = 0;
    bit m_fail = 0, m_upper = 0, m_done = 0;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_cnt = 0; m_left = 0; m_tmo = 0;
            m_fail = 0; m_upper = 0; m_done = 0;
        end else begin
            bit idle, fire, clr;
            idle = !en || m_tmo == 0 || m_fail || m_left > 0;
            fire = !idle && !m_done && sec_tick && (m_cnt + 1 >= m_tmo);
            clr  = wr_en && wr_addr == 2 && wr_data[0];
            if (idle) m_cnt = 0;
            else if (sec_tick && !m_done) m_cnt = fire ? 0 : m_cnt + 1;
            if (fire) m_left = 16;
            else if (m_left > 0) m_left--;
            if (fire) m_fail = 1;
            else if (clr) m_fail = 0;
            if (wr_en && wr_addr == 0) m_tmo = wr_data;
            if (wr_en && wr_addr == 1) begin
                m_upper = wr_data[0];
                m_done  = wr_data[1];
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the model (R2 R3 R7 R8)
    always @(negedge clk) begin
        if (!rst) begin
            chk(sys_rst_o == (m_left > 0), "R3 sys_rst_o vs model", sys_rst_o, m_left > 0);
            chk(fail_o == m_fail, "R2 fail_o vs model", fail_o, m_fail);
            chk(cs_sel_o == (m_fail && !m_upper), "R7 cs_sel_o vs model", cs_sel_o, m_fail && !m_upper);
            chk(addr_msb_o == (m_fail && m_upper), "R7 addr_msb_o vs model", addr_msb_o, m_fail && m_upper);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        idle(2);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // Tick and report how many ticks it took until fail_o rose (0 = never).
    task automatic ticks_until_fail(input int maxn, output int took);
        took = 0;
        for (int i = 1; i <= maxn; i++) begin
            @(negedge clk);
            sec_tick = 1'b1;
            @(negedge clk);
            sec_tick = 1'b0;
            if (fail_o && took == 0) took = i;
            idle(2);
        end
    endtask

    initial begin
        int took, hi;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(!sys_rst_o && !fail_o && !cs_sel_o && !addr_msb_o, "R1 outputs after reset",
            {sys_rst_o, fail_o, cs_sel_o, addr_msb_o}, 0);

        // R4: zero timeout never fires
        en = 1'b1;
        ticks_until_fail(20, took);
        chk(took == 0, "R4 zero timeout", took, 0);

        // R2 + R7 chip-select mode
        wr(0, 8'd3);
        wr(1, 8'h00);
        @(negedge clk);
        sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0; idle(2);
        sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0;
        chk(!fail_o, "R2 no fail before T ticks", fail_o, 0);
        idle(2);
        sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0;
        chk(fail_o, "R2 fail on T-th tick", fail_o, 1);
        chk(cs_sel_o && !addr_msb_o, "R7 chip-select steering", {cs_sel_o, addr_msb_o}, 2);
        // R3: count reset high cycles
        hi = 0;
        for (int i = 0; i < 40; i++) begin
            if (sys_rst_o) hi++;
            @(negedge clk);
        end
        chk(hi == 16, "R3 reset pulse length", hi, 16);

        // R9: ticks during failure produce no second reset
        hi = 0;
        for (int i = 0; i < 10; i++) begin
            tick();
            if (sys_rst_o) hi++;
        end
        chk(hi == 0 && fail_o, "R9 no rearm while failed", hi, 0);

        // R8: write 0 keeps, write 1 clears
        wr(2, 8'h00);
        chk(fail_o, "R8 write 0 keeps flag", fail_o, 1);
        wr(2, 8'h01);
        chk(!fail_o && !cs_sel_o, "R8 write 1 clears flag", fail_o, 0);

        // R7 upper-half mode, R9 restart from zero
        wr(1, 8'h01);
        wr(0, 8'd2);
        ticks_until_fail(5, took);
        chk(took == 2, "R9 restart from zero after clear", took, 2);
        chk(addr_msb_o && !cs_sel_o, "R7 upper-half steering", {cs_sel_o, addr_msb_o}, 1);
        idle(20);
        wr(2, 8'h01);

        // R6: boot done holds the count
        wr(0, 8'd3);
        tick();
        wr(1, 8'h03);
        ticks_until_fail(10, took);
        chk(took == 0, "R6 boot done stops timeout", took, 0);
        wr(1, 8'h01);
        ticks_until_fail(5, took);
        chk(took == 2, "R6 resume from held count", took, 2);
        idle(20);
        wr(2, 8'h01);

        // R5: enable low discards progress
        ticks(2);
        @(negedge clk); en = 1'b0;
        @(negedge clk); en = 1'b1;
        ticks_until_fail(2, took);
        chk(took == 0, "R5 enable low clears count", took, 0);
        ticks_until_fail(2, took);
        chk(took == 1, "R5 count rebuilt after enable", took, 1);
        idle(20);
        wr(2, 8'h01);

        // R2: timeout lowered below count fires on next tick
        wr(0, 8'd10);
        ticks(4);
        wr(0, 8'd2);
        ticks_until_fail(3, took);
        chk(took == 1, "R2 lowered timeout fires next tick", took, 1);
        idle(20);

        // R1: reset clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk(!sys_rst_o && !fail_o && !cs_sel_o && !addr_msb_o, "R1 outputs after re-reset",
            {sys_rst_o, fail_o, cs_sel_o, addr_msb_o}, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog timeout actual=%0d expected=0", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule